// File: doc/BRIEF.md
# Serial Memory Slave Command Front-End

This block sits between a two-wire serial bus (SCL and SDA) and a byte-wide synchronous memory port. It follows the bus framing and recognises the bus conditions that open and close a transaction. It decodes a device-select byte that carries a type code, a chip-select bit and the top address bit. It then collects a 17-bit byte address and turns each data byte into a single-cycle write or read request on the memory port. The block pulls SDA low through an output enable. An external pull-up supplies the high level.

The bus inputs first pass through a two-flop synchroniser, and the whole block runs on the system clock. A master writes by sending the select byte with the direction bit clear, the high address byte, the low address byte and then data. To read from an arbitrary address, the master loads the address the same way, issues a repeated START and sends the select byte with the direction bit set. It acknowledges each byte it wants followed by another and ends with a not-acknowledge and a STOP.

Top module: `i2c_mem_fe`

## Requirements
- R1: After reset, sda_oe, mem_we and mem_re are low and the block is idle.
- R2: START (SDA falls while SCL high) and STOP (SDA rises while SCL high) are honoured in every state. START restarts byte framing and expects a select byte. STOP returns the block to idle.
- R3: Bits clocked while idle, before any START, produce no acknowledge and no memory access.
- R4: The select byte is received MSB first as bits [7:4] type code 1010, bit [3] a fixed 0, bit [2] the chip-select bit, bit [1] the top address bit and bit [0] the direction (1 = read). When bits [7:3] match and bit [2] equals sel_a1, the block acknowledges by pulling SDA low for the ninth clock.
- R5: A select byte that does not match is not acknowledged. Every later bit up to the next START or STOP is ignored: no acknowledge and no memory access.
- R6: After a write select byte, two address bytes follow, high byte first. Each is acknowledged. The memory address is {select bit [1], high byte, low byte}.
- R7: In a write, every data byte after the address bytes is acknowledged and produces one mem_we pulse carrying the current address and the byte. The low 16 address bits then increment, wrapping from FFFF to 0000 with bit 16 kept.
- R8: A read select byte returns the byte at the current address, MSB first. A master acknowledge advances the low 16 address bits and starts the next byte. A master not-acknowledge leaves the address unchanged and releases SDA until the next START or STOP.
- R9: sda_oe rises only while the synchronised SCL is low. SDA is never driven high.
- R10: mem_re is a one-cycle pulse, and mem_rdata is taken in the cycle after it. SCL high and low times must each be at least 8 clock cycles.
- R11: mem_we and mem_re are never high together, and mem_we occurs only during the write-data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| sel_a1 | input | 1 | Chip-select strap compared with select bit [2] |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |
| sda_oe | output | 1 | Pull SDA low when high |
| mem_we | output | 1 | One-cycle write strobe |
| mem_re | output | 1 | One-cycle read strobe |
| mem_addr | output | 17 | Memory byte address |
| mem_wdata | output | 8 | Write data |

## Verification
The decode is tried with a matching select byte and with three near misses: a wrong chip-select bit, a wrong type code and the fixed bit set. These separate a correct field-by-field compare from a partial one. Writes and reads are run with the top address bit both set and clear, at an ordinary address and at the FFFF boundary of the low 16 bits. This shows that bit 16 comes from the select byte and survives the wrap. Reads close with both an acknowledge and a not-acknowledge, and a current-address read follows, so increment-on-ACK can be told apart from increment-on-every-byte. Stray bits before any START, a START in the middle of a byte and a STOP in the middle of a byte show that framing follows the bus conditions alone.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
  localparam int BYTE_W  = 8;
  localparam int ARR_W   = 16;
  localparam int MEM_AW  = ARR_W + 1;
  localparam logic [3:0] TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD,
    ST_SKIP
  } fe_state_e;
endpackage

// File: rtl/i2cfe_sync.sv
module i2cfe_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_n;
    always_comb chain_n = {chain_q[STAGES-2:0], d[i]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_n;
    end
    assign q[i] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2cfe_cond.sv
module i2cfe_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cfe_engine.sv
module i2cfe_engine
  import i2cfe_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = TYPE_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sel_a1,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sda_oe,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam int IDX_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_ACK = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] TOP_BIT = CNT_W'(BYTE_W - 1);

  fe_state_e          st_q, st_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [BYTE_W-1:0]  sh_q, sh_n;
  logic [MEM_AW-1:0]  addr_q, addr_n;
  logic [BYTE_W-1:0]  hold_q, hold_n;
  logic [BYTE_W-1:0]  wd_q, wd_n;
  logic               oe_q, oe_n;
  logic               we_q, we_n;
  logic               re_q, re_n;
  logic               kick_q, kick_n;
  logic               rdv_q, rdv_n;
  logic               mack_q, mack_n;
  logic               sel_ok;
  logic [IDX_W-1:0]   bit_idx;

  assign sel_ok  = (sh_q[7:4] == DEV_TYPE) && !sh_q[3] && (sh_q[2] == sel_a1);
  assign bit_idx = IDX_W'(TOP_BIT - cnt_q);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    sh_n   = sh_q;
    addr_n = addr_q;
    wd_n   = wd_q;
    oe_n   = oe_q;
    mack_n = mack_q;
    we_n   = 1'b0;
    kick_n = 1'b0;
    re_n   = kick_q;
    rdv_n  = re_q;
    hold_n = rdv_q ? mem_rdata : hold_q;
    if (stop_det) begin
      st_n  = ST_IDLE;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (start_det) begin
      st_n  = ST_DEV;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (st_q != ST_IDLE && st_q != ST_SKIP) begin
      if (scl_rise) begin
        if (cnt_q < CNT_ACK) begin
          cnt_n = cnt_q + 1'b1;
          if (st_q != ST_RD) sh_n = {sh_q[BYTE_W-2:0], sda_s};
        end else if (cnt_q == CNT_ACK) begin
          cnt_n = CNT_END;
          if (st_q == ST_RD) begin
            mack_n = ~sda_s;
            if (!sda_s) begin
              addr_n[ARR_W-1:0] = addr_q[ARR_W-1:0] + ARR_W'(1);
              kick_n = 1'b1;
            end
          end
        end
      end else if (scl_fall) begin
        if (cnt_q == CNT_ACK) begin
          case (st_q)
            ST_DEV: begin
              if (sel_ok) begin
                oe_n          = 1'b1;
                addr_n[ARR_W] = sh_q[1];
                kick_n        = sh_q[0];
              end else begin
                st_n = ST_SKIP;
              end
            end
            ST_AHI: begin
              oe_n = 1'b1;
              addr_n[ARR_W-1:BYTE_W] = sh_q;
            end
            ST_ALO: begin
              oe_n = 1'b1;
              addr_n[BYTE_W-1:0] = sh_q;
            end
            ST_WR: begin
              oe_n = 1'b1;
              we_n = 1'b1;
              wd_n = sh_q;
            end
            default: oe_n = 1'b0;
          endcase
        end else if (cnt_q == CNT_END) begin
          cnt_n = '0;
          oe_n  = 1'b0;
          case (st_q)
            ST_DEV: begin
              st_n = sh_q[0] ? ST_RD : ST_AHI;
              oe_n = sh_q[0] & ~hold_q[BYTE_W-1];
            end
            ST_AHI: st_n = ST_ALO;
            ST_ALO: st_n = ST_WR;
            ST_WR:  addr_n[ARR_W-1:0] = addr_q[ARR_W-1:0] + ARR_W'(1);
            ST_RD: begin
              if (mack_q) oe_n = ~hold_q[BYTE_W-1];
              else        st_n = ST_SKIP;
            end
            default: st_n = st_q;
          endcase
        end else if (st_q == ST_RD) begin
          oe_n = ~hold_q[bit_idx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      sh_q   <= '0;
      addr_q <= '0;
      hold_q <= '0;
      wd_q   <= '0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      re_q   <= 1'b0;
      kick_q <= 1'b0;
      rdv_q  <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      sh_q   <= sh_n;
      addr_q <= addr_n;
      hold_q <= hold_n;
      wd_q   <= wd_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
      re_q   <= re_n;
      kick_q <= kick_n;
      rdv_q  <= rdv_n;
      mack_q <= mack_n;
    end
  end

  assign sda_oe    = oe_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;

  // R2
  start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st_q == ST_DEV && cnt_q == '0));
  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE && !oe_q));
  // R9
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> !scl_s);
  // R5
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_SKIP) |-> !oe_q);
  // R11
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_q && re_q));
  // R11
  we_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> st_q == ST_WR);
  // R8
  rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD && cnt_q == CNT_END) |-> !oe_q);
  // R10
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    re_q |=> !re_q);
endmodule

// File: rtl/i2c_mem_fe.sv
module i2c_mem_fe
  import i2cfe_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = TYPE_CODE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sel_a1,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic              sda_oe,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata
);
  logic [1:0] bus_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cfe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d ({scl_i, sda_i}),
    .q (bus_s)
  );

  i2cfe_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2cfe_engine #(.DEV_TYPE(DEV_TYPE)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (bus_s[1]),
    .sda_s     (bus_s[0]),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sel_a1    (sel_a1),
    .mem_rdata (mem_rdata),
    .sda_oe    (sda_oe),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );
endmodule

// File: tb/i2c_mem_fe_tb.sv
`timescale 1ns/1ps
module i2c_mem_fe_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sdal = 1'b0;
  logic sel_a1 = 1'b1;
  logic [7:0]  mem_rdata = 8'h00;
  logic        sda_oe, mem_we, mem_re;
  logic [16:0] mem_addr;
  logic [7:0]  mem_wdata;
  wire         sda_bus = ~(sdal | sda_oe);

  int n_chk = 0;
  int n_bad = 0;
  int we_cnt = 0;
  int re_cnt = 0;
  int r9_bad = 0;
  int r10_bad = 0;
  int r11_bad = 0;
  bit done = 1'b0;

  typedef struct packed { logic [16:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];
  logic [7:0] bmem [int];

  always #4 clk = ~clk;

  i2c_mem_fe u_dut (
    .clk (clk), .rst_n (rst_n), .scl_i (scl), .sda_i (sda_bus),
    .sel_a1 (sel_a1), .mem_rdata (mem_rdata), .sda_oe (sda_oe),
    .mem_we (mem_we), .mem_re (mem_re), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always @(posedge clk) begin
    if (mem_we) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_re) mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'hEE;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops expected writes, watches port rules
  logic scl_p = 1'b1, oe_p = 1'b0, re_p = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        we_cnt++;
        if (exp_q.size() == 0) check(1'b0, "R5/R7 unexpected write", {15'd0, mem_addr}, 0);
        else begin
          wr_t e;
          e = exp_q.pop_front();
          check(mem_addr == e.a && mem_wdata == e.d, "R7 write item",
                {7'd0, mem_addr, mem_wdata}, {7'd0, e.a, e.d});
        end
      end
      if (mem_re) re_cnt++;
      if (sda_oe && !oe_p && scl && scl_p) r9_bad++;
      if (mem_re && re_p) r10_bad++;
      if (mem_we && mem_re) r11_bad++;
    end
    scl_p = scl; oe_p = sda_oe; re_p = mem_re;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] dev(input logic a1, input logic hi, input logic rw);
    return {4'b1010, 1'b0, a1, hi, rw};
  endfunction

  task automatic do_start();
    sdal = 1'b0; tick(Q); scl = 1'b1; tick(Q); sdal = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic do_stop();
    sdal = 1'b1; tick(Q); scl = 1'b1; tick(Q); sdal = 1'b0; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sdal = ~b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sdal = 1'b0; tick(Q); scl = 1'b1; tick(Q); ack = ~sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdal = 1'b0; tick(Q); scl = 1'b1; tick(Q); v[i] = sda_bus; tick(Q); scl = 1'b0; tick(Q);
    end
    sdal = give_ack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q); sdal = 1'b0;
  endtask

  task automatic send_expect(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    send_byte(b, ack);
    check(ack == exp_ack, tag, {31'd0, ack}, {31'd0, exp_ack});
  endtask

  task automatic set_addr(input logic [16:0] a);
    do_start();
    send_expect(dev(1'b1, a[16], 1'b0), 1'b1, "R4 select ack");
    send_expect(a[15:8], 1'b1, "R6 high address ack");
    send_expect(a[7:0], 1'b1, "R6 low address ack");
  endtask

  task automatic write2(input logic [16:0] a, input logic [7:0] d0, input logic [7:0] d1);
    wr_t e;
    set_addr(a);
    e.a = a; e.d = d0; exp_q.push_back(e);
    e.a = {a[16], a[15:0] + 16'd1}; e.d = d1; exp_q.push_back(e);
    send_expect(d0, 1'b1, "R7 data ack");
    send_expect(d1, 1'b1, "R7 data ack");
    do_stop();
    check(exp_q.size() == 0, "R7 writes drained", exp_q.size(), 0);
  endtask

  task automatic rd_at(input logic [16:0] a, input logic [7:0] e0, input logic [7:0] e1);
    logic [7:0] v;
    set_addr(a);
    do_start();
    send_expect(dev(1'b1, a[16], 1'b1), 1'b1, "R4 read select ack");
    recv_byte(1'b1, v);
    check(v == e0, "R8/R10 read byte", {24'd0, v}, {24'd0, e0});
    recv_byte(1'b0, v);
    check(v == e1, "R8 read after master ack", {24'd0, v}, {24'd0, e1});
    check(sda_oe == 1'b0, "R8 release after nack", {31'd0, sda_oe}, 0);
    do_stop();
  endtask

  initial begin
    logic [7:0] v;
    int wc, rc;
    wr_t e;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R1
    check(!sda_oe && !mem_we && !mem_re, "R1 reset outputs", {29'd0, sda_oe, mem_we, mem_re}, 0);

    // R3: full matching byte with no START
    send_expect(dev(1'b1, 1'b1, 1'b0), 1'b0, "R3 no ack before START");
    check(we_cnt == 0 && re_cnt == 0, "R3 no access before START", we_cnt + re_cnt, 0);

    // R2: START inside a byte restarts framing
    do_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    sdal = 1'b0; tick(Q); scl = 1'b1; tick(Q); sdal = 1'b1; tick(Q); scl = 1'b0; tick(Q);
    send_expect(dev(1'b1, 1'b1, 1'b0), 1'b1, "R2 ack after restart mid-byte");
    send_expect(8'h23, 1'b1, "R6 high address ack");
    send_expect(8'h45, 1'b1, "R6 low address ack");
    e.a = 17'h12345; e.d = 8'hA5; exp_q.push_back(e);
    e.a = 17'h12346; e.d = 8'h3C; exp_q.push_back(e);
    e.a = 17'h12347; e.d = 8'h77; exp_q.push_back(e);
    send_expect(8'hA5, 1'b1, "R7 data ack");
    send_expect(8'h3C, 1'b1, "R7 data ack");
    send_expect(8'h77, 1'b1, "R7 data ack");
    do_stop();
    check(exp_q.size() == 0, "R7 writes drained", exp_q.size(), 0);

    // R8: random read, three bytes
    set_addr(17'h12345);
    do_start();
    send_expect(dev(1'b1, 1'b1, 1'b1), 1'b1, "R4 read select ack");
    recv_byte(1'b1, v); check(v == 8'hA5, "R8 byte 0", {24'd0, v}, 32'hA5);
    recv_byte(1'b1, v); check(v == 8'h3C, "R8 byte 1", {24'd0, v}, 32'h3C);
    recv_byte(1'b0, v); check(v == 8'h77, "R8 byte 2", {24'd0, v}, 32'h77);
    check(sda_oe == 1'b0, "R8 release after nack", {31'd0, sda_oe}, 0);
    do_stop();
    // R8: nack did not advance, current read returns 0x12347
    do_start();
    send_expect(dev(1'b1, 1'b1, 1'b1), 1'b1, "R4 current read ack");
    recv_byte(1'b0, v); check(v == 8'h77, "R8 current address no advance on nack", {24'd0, v}, 32'h77);
    do_stop();

    // R6: bit 16 from select byte
    write2(17'h02345, 8'h5A, 8'h6B);
    rd_at(17'h02345, 8'h5A, 8'h6B);
    rd_at(17'h12345, 8'hA5, 8'h3C);

    // R7: low 16-bit wrap keeps bit 16
    write2(17'h1FFFF, 8'h11, 8'h22);
    rd_at(17'h1FFFF, 8'h11, 8'h22);

    // R5: near-miss select bytes
    wc = we_cnt; rc = re_cnt;
    do_start();
    send_expect(dev(1'b0, 1'b1, 1'b0), 1'b0, "R5 wrong chip-select nack");
    send_expect(8'h23, 1'b0, "R5 ignored address");
    send_expect(8'h45, 1'b0, "R5 ignored address");
    send_expect(8'h99, 1'b0, "R5 ignored data");
    do_stop();
    do_start();
    send_expect(8'hB4, 1'b0, "R5 wrong type code nack");
    do_stop();
    do_start();
    send_expect(8'hAC, 1'b0, "R5 fixed bit set nack");
    send_expect(dev(1'b1, 1'b1, 1'b0), 1'b0, "R5 matching byte ignored until START");
    do_stop();
    check(we_cnt == wc && re_cnt == rc, "R5 no memory access", we_cnt + re_cnt, wc + rc);

    // R2: STOP mid-byte then stray byte
    do_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    sdal = 1'b1; tick(Q); scl = 1'b1; tick(Q); sdal = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
    send_expect(dev(1'b1, 1'b1, 1'b0), 1'b0, "R2 idle after STOP");
    scl = 1'b1; tick(Q);
    rd_at(17'h12347, 8'h77, 8'hEE);

    check(r9_bad == 0, "R9 oe rose while SCL high", r9_bad, 0);
    check(r10_bad == 0, "R10 read strobe longer than one cycle", r10_bad, 0);
    check(r11_bad == 0, "R11 write and read strobes together", r11_bad, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R1-chain actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule